// File: doc/BRIEF.md
# Memory-Card Host Status and Interrupt Unit

This block keeps the status word and the interrupt-enable word of a memory-card host controller. The command engine, the data engine, the buffer logic and the card-detect logic report events to it as one-cycle pulses. Each event sets a sticky bit in the status word, and the bit stays set until software writes a one to that position. Conditions owned by the buffers (empty, full, ready, underrun, overflow, SDIO interrupt active) are sampled every cycle and shown as live levels. Writes to those positions have no effect.

Software reaches both words through one small register port. A one-bit address selects the word: 0 is the status word and 1 is the interrupt-enable word. Reads are combinational from the selected word. A single interrupt request is raised while any enabled event is pending. Two summary outputs help a polling driver. One flags that any error bit is set. The other flags that the last write-CRC status code reported that the card sent no CRC token.

Top module: `card_host_stat`

## Requirements
- R1: After reset the status word and the enable word both read 0, and irq, err_any and no_crc_token are 0.
- R2: A pulse on an event input sets its status bit on the next clock edge, and the bit then stays set. The positions are: card inserted 31, card removed 30, command response end 13, write done 12, read done 11, response CRC error 5, read CRC error 3, write CRC error 2, response timeout 1, read timeout 0.
- R3: A write to the status word (reg_addr = 0) clears every event bit whose write-data bit is 1. Bits written with 0 are left unchanged.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit is set after the edge.
- R5: The level bits are: second buffer empty 29, first buffer empty 28, second buffer full 27, first buffer full 26, underrun 25, overflow 24, SDIO interrupt active 14, read ready 7, write ready 6. Each shows its input as sampled at the previous clock edge, and writes to the status word do not change it.
- R6: A pulse on ev_wr_crc loads wr_crc_code into status bits 10:9 and sets bit 2. The code bits are cleared by writing ones to them. no_crc_token is 1 exactly when the code field holds the value 2.
- R7: err_any is 1 while any of status bits 0, 1, 2, 3 or 5 (mask 0x2F) is set.
- R8: A write with reg_addr = 1 loads the enable word. Only bits 4:0 and 18:12 (mask 0x0007F01F) are stored, and all other bits read 0. The enable word keeps its value when no write is made to it.
- R9: irq is 1 while any enabled pair is set. The pairs are enable bit 0 with status 11, 1 with 12, 2 with 13, 3 with 6, 4 with 7, 13 with 14, 14 with 30, and 15 with 31. Error bits alone never raise irq.
- R10: Status positions 4, 8 and 15 to 23 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 status, 1 interrupt enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| ev_card_in | input | 1 | Card inserted pulse |
| ev_card_out | input | 1 | Card removed pulse |
| ev_cmd_end | input | 1 | Command response end pulse |
| ev_wr_done | input | 1 | Write operation done pulse |
| ev_rd_done | input | 1 | Read operation done pulse |
| ev_resp_crc | input | 1 | Response CRC error pulse |
| ev_rd_crc | input | 1 | Read CRC error pulse |
| ev_wr_crc | input | 1 | Write CRC error pulse |
| wr_crc_code | input | 2 | Write CRC status code that goes with ev_wr_crc |
| ev_resp_to | input | 1 | Response timeout pulse |
| ev_rd_to | input | 1 | Read timeout pulse |
| lv_buf2_empty | input | 1 | Second buffer empty level |
| lv_buf1_empty | input | 1 | First buffer empty level |
| lv_buf2_full | input | 1 | Second buffer full level |
| lv_buf1_full | input | 1 | First buffer full level |
| lv_underrun | input | 1 | Buffer underrun level |
| lv_overflow | input | 1 | Buffer overflow level |
| lv_sdio_act | input | 1 | SDIO interrupt active level |
| lv_rd_ready | input | 1 | Buffer read ready level |
| lv_wr_ready | input | 1 | Buffer write ready level |
| irq | output | 1 | Interrupt request |
| err_any | output | 1 | Any error bit set |
| no_crc_token | output | 1 | Write CRC code field holds 2 |

## Verification
The hardest situation to create from the ports is the collision: a clearing write and a new event on the same bit in the same clock cycle. A correct design and one that lets the clear win differ only in that one cycle. The stimulus raises the card-insert pulse in the very cycle that a status write clears both bit 31 and bit 13. It then expects bit 31 to stay set and bit 13 to drop. The bench also holds every level input high during an all-ones clearing write, which shows that the clear does not reach the live bits.

// File: rtl/card_stat_pkg.sv
package card_stat_pkg;
  localparam int STAT_W = 32;
  localparam int CODE_W = 2;
  localparam int CODE_LSB = 9;
  localparam int LVL_N = 9;
  localparam logic [STAT_W-1:0] EVT_MASK = 32'hC000_382F;
  localparam logic [STAT_W-1:0] ERR_MASK = 32'h0000_002F;
  localparam logic [STAT_W-1:0] IEN_MASK = 32'h0007_F01F;
  localparam logic [CODE_W-1:0] CODE_NO_TOKEN = 2'd2;

  // status bit positions
  localparam int B_CARD_IN  = 31;
  localparam int B_CARD_OUT = 30;
  localparam int B_B2_EMPTY = 29;
  localparam int B_B1_EMPTY = 28;
  localparam int B_B2_FULL  = 27;
  localparam int B_B1_FULL  = 26;
  localparam int B_UNDERRUN = 25;
  localparam int B_OVERFLOW = 24;
  localparam int B_SDIO     = 14;
  localparam int B_CMD_END  = 13;
  localparam int B_WR_DONE  = 12;
  localparam int B_RD_DONE  = 11;
  localparam int B_RD_RDY   = 7;
  localparam int B_WR_RDY   = 6;
  localparam int B_RESP_CRC = 5;
  localparam int B_RD_CRC   = 3;
  localparam int B_WR_CRC   = 2;
  localparam int B_RESP_TO  = 1;
  localparam int B_RD_TO    = 0;

  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic logic irq_from(input logic [STAT_W-1:0] st, input logic [STAT_W-1:0] en);
    logic [7:0] pend;
    pend[0] = en[0]  & st[B_RD_DONE];
    pend[1] = en[1]  & st[B_WR_DONE];
    pend[2] = en[2]  & st[B_CMD_END];
    pend[3] = en[3]  & st[B_WR_RDY];
    pend[4] = en[4]  & st[B_RD_RDY];
    pend[5] = en[13] & st[B_SDIO];
    pend[6] = en[14] & st[B_CARD_OUT];
    pend[7] = en[15] & st[B_CARD_IN];
    return |pend;
  endfunction
endpackage

// File: rtl/card_stat_sticky.sv
module card_stat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  import card_stat_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= sticky_next(q_o, set_i, clr_i);
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n) set_i |=> q_o);
  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n) (clr_i && !set_i) |=> !q_o);
  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n) (q_o && !clr_i) |=> q_o);
  p_race_r4: assert property (@(posedge clk) disable iff (!rst_n) (set_i && clr_i) |=> q_o);
endmodule

// File: rtl/card_stat_code.sv
module card_stat_code #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] code_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] code_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_o <= '0;
    else if (load_i) code_o <= code_i;
    else             code_o <= code_o & ~clr_i;
  end

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n) load_i |=> (code_o == $past(code_i)));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && clr_i == '0) |=> $stable(code_o));
endmodule

// File: rtl/card_stat_levels.sv
module card_stat_levels #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] lvl_o
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o   <= '0;
      past_ok <= 1'b0;
    end else begin
      lvl_o   <= lvl_i;
      past_ok <= 1'b1;
    end
  end

  p_follow_r5: assert property (@(posedge clk) disable iff (!rst_n) past_ok |-> (lvl_o == $past(lvl_i)));
endmodule

// File: rtl/card_stat_irq.sv
module card_stat_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  import card_stat_pkg::*;

  assign irq_o = irq_from(stat_i, en_i);

  p_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> (en_i != '0));
  p_needs_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((stat_i & ~ERR_MASK) != '0));
endmodule

// File: rtl/card_host_stat.sv
module card_host_stat
  import card_stat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ev_card_in,
  input  logic        ev_card_out,
  input  logic        ev_cmd_end,
  input  logic        ev_wr_done,
  input  logic        ev_rd_done,
  input  logic        ev_resp_crc,
  input  logic        ev_rd_crc,
  input  logic        ev_wr_crc,
  input  logic [1:0]  wr_crc_code,
  input  logic        ev_resp_to,
  input  logic        ev_rd_to,
  input  logic        lv_buf2_empty,
  input  logic        lv_buf1_empty,
  input  logic        lv_buf2_full,
  input  logic        lv_buf1_full,
  input  logic        lv_underrun,
  input  logic        lv_overflow,
  input  logic        lv_sdio_act,
  input  logic        lv_rd_ready,
  input  logic        lv_wr_ready,
  output logic        irq,
  output logic        err_any,
  output logic        no_crc_token
);
  logic [STAT_W-1:0] evt_vec;
  logic [STAT_W-1:0] sticky;
  logic [STAT_W-1:0] lvl_word;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] en_q;
  logic [LVL_N-1:0]  lvl_raw;
  logic [LVL_N-1:0]  lvl_q;
  logic [CODE_W-1:0] code_q;
  logic              stat_wr;
  logic              en_wr;

  assign stat_wr = reg_wr && !reg_addr;
  assign en_wr   = reg_wr && reg_addr;

  always_comb begin
    evt_vec = '0;
    evt_vec[B_CARD_IN]  = ev_card_in;
    evt_vec[B_CARD_OUT] = ev_card_out;
    evt_vec[B_CMD_END]  = ev_cmd_end;
    evt_vec[B_WR_DONE]  = ev_wr_done;
    evt_vec[B_RD_DONE]  = ev_rd_done;
    evt_vec[B_RESP_CRC] = ev_resp_crc;
    evt_vec[B_RD_CRC]   = ev_rd_crc;
    evt_vec[B_WR_CRC]   = ev_wr_crc;
    evt_vec[B_RESP_TO]  = ev_resp_to;
    evt_vec[B_RD_TO]    = ev_rd_to;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (EVT_MASK[b]) begin : g_evt
      card_stat_sticky u_bit (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(evt_vec[b]),
        .clr_i(stat_wr & reg_wdata[b]),
        .q_o  (sticky[b])
      );
    end else begin : g_none
      assign sticky[b] = 1'b0;
    end
  end

  card_stat_code #(.W(CODE_W)) u_code (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(ev_wr_crc),
    .code_i(wr_crc_code),
    .clr_i (stat_wr ? reg_wdata[CODE_LSB +: CODE_W] : '0),
    .code_o(code_q)
  );

  assign lvl_raw = {lv_buf2_empty, lv_buf1_empty, lv_buf2_full, lv_buf1_full,
                    lv_underrun, lv_overflow, lv_sdio_act, lv_rd_ready, lv_wr_ready};

  card_stat_levels #(.N(LVL_N)) u_lvl (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl_i(lvl_raw),
    .lvl_o(lvl_q)
  );

  always_comb begin
    lvl_word = '0;
    lvl_word[B_B2_EMPTY] = lvl_q[8];
    lvl_word[B_B1_EMPTY] = lvl_q[7];
    lvl_word[B_B2_FULL]  = lvl_q[6];
    lvl_word[B_B1_FULL]  = lvl_q[5];
    lvl_word[B_UNDERRUN] = lvl_q[4];
    lvl_word[B_OVERFLOW] = lvl_q[3];
    lvl_word[B_SDIO]     = lvl_q[2];
    lvl_word[B_RD_RDY]   = lvl_q[1];
    lvl_word[B_WR_RDY]   = lvl_q[0];
  end

  assign status = sticky | lvl_word | (STAT_W'(code_q) << CODE_LSB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= reg_wdata & IEN_MASK;
  end

  card_stat_irq #(.W(STAT_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .stat_i(status),
    .en_i  (en_q),
    .irq_o (irq)
  );

  assign reg_rdata    = reg_addr ? en_q : status;
  assign err_any      = |(status & ERR_MASK);
  assign no_crc_token = (code_q == CODE_NO_TOKEN);

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) !en_wr |=> $stable(en_q));
  p_err_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_resp_to || ev_rd_to || ev_rd_crc || ev_wr_crc || ev_resp_crc) |=> err_any);
endmodule

// File: tb/test_card_host_stat.sv
module test_card_host_stat;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ev_card_in = 0, ev_card_out = 0, ev_cmd_end = 0, ev_wr_done = 0, ev_rd_done = 0;
  logic ev_resp_crc = 0, ev_rd_crc = 0, ev_wr_crc = 0, ev_resp_to = 0, ev_rd_to = 0;
  logic [1:0] wr_crc_code = '0;
  logic lv_buf2_empty = 0, lv_buf1_empty = 0, lv_buf2_full = 0, lv_buf1_full = 0;
  logic lv_underrun = 0, lv_overflow = 0, lv_sdio_act = 0, lv_rd_ready = 0, lv_wr_ready = 0;
  logic irq, err_any, no_crc_token;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic        addr;
    logic [31:0] rd;
    logic        irq;
    logic        err;
    logic        nct;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  card_host_stat i_card_host_stat (.*);

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (sb.size() != 0);
      #1;
      begin
        item_t it;
        it = sb[0];
        checks++;
        if (reg_rdata !== it.rd || irq !== it.irq || err_any !== it.err || no_crc_token !== it.nct) begin
          failures++;
          $display("FAIL %s: rdata=%h irq=%b err=%b nct=%b expected rdata=%h irq=%b err=%b nct=%b",
                   it.tag, reg_rdata, irq, err_any, no_crc_token, it.rd, it.irq, it.err, it.nct);
        end
        void'(sb.pop_front());
      end
    end
  end

  task automatic expect_rd(input logic a, input logic [31:0] rd, input logic i,
                           input logic e, input logic n, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.addr = a; it.rd = rd; it.irq = i; it.err = e; it.nct = n; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_card_in = 1;   1: ev_card_out = 1;  2: ev_cmd_end = 1;
      3: ev_wr_done = 1;   4: ev_rd_done = 1;   5: ev_resp_crc = 1;
      6: ev_rd_crc = 1;    7: ev_wr_crc = 1;    8: ev_resp_to = 1;
      default: ev_rd_to = 1;
    endcase
    @(negedge clk);
    {ev_card_in, ev_card_out, ev_cmd_end, ev_wr_done, ev_rd_done,
     ev_resp_crc, ev_rd_crc, ev_wr_crc, ev_resp_to, ev_rd_to} = '0;
  endtask

  task automatic set_levels(input logic v);
    @(negedge clk);
    {lv_buf2_empty, lv_buf1_empty, lv_buf2_full, lv_buf1_full,
     lv_underrun, lv_overflow, lv_sdio_act, lv_rd_ready, lv_wr_ready} = {9{v}};
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_rd(0, 32'h0, 0, 0, 0, "R1 status after reset");
    expect_rd(1, 32'h0, 0, 0, 0, "R1 enable after reset");

    pulse(2);
    expect_rd(0, 32'h0000_2000, 0, 0, 0, "R2 cmd end bit 13");
    pulse(0);
    expect_rd(0, 32'h8000_2000, 0, 0, 0, "R2 card in bit 31");
    @(negedge clk); ev_rd_done = 1; ev_wr_done = 1; ev_card_out = 1;
    @(negedge clk); ev_rd_done = 0; ev_wr_done = 0; ev_card_out = 0;
    expect_rd(0, 32'hC000_3800, 0, 0, 0, "R2 done bits 11,12 and card out 30");

    wr(0, 32'h4000_1000);
    expect_rd(0, 32'h8000_2800, 0, 0, 0, "R3 write one clears");
    wr(0, 32'h0);
    expect_rd(0, 32'h8000_2800, 0, 0, 0, "R3 write zero keeps");

    // collision: event on bit 31 while bits 31 and 13 are cleared
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 32'h8000_2000; ev_card_in = 1;
    @(negedge clk); reg_wr = 0; reg_wdata = '0; ev_card_in = 0;
    expect_rd(0, 32'h8000_0800, 0, 0, 0, "R4 event wins over clear");

    wr(0, 32'hFFFF_FFFF);
    expect_rd(0, 32'h0, 0, 0, 0, "R10 unused bits zero after all-ones write");

    pulse(8);
    expect_rd(0, 32'h0000_0002, 0, 1, 0, "R7 response timeout error");
    wr(0, 32'h2);
    expect_rd(0, 32'h0, 0, 0, 0, "R7 error cleared");
    pulse(5); pulse(6); pulse(9);
    expect_rd(0, 32'h0000_0029, 0, 1, 0, "R7 CRC and read timeout errors");
    wr(0, 32'hFFFF_FFFF);

    @(negedge clk); wr_crc_code = 2'd2;
    pulse(7);
    expect_rd(0, 32'h0000_0404, 0, 1, 1, "R6 code 2 no token");
    wr(0, 32'h0000_0400);
    expect_rd(0, 32'h0000_0004, 0, 1, 0, "R6 code bits cleared");
    wr(0, 32'h4);
    @(negedge clk); wr_crc_code = 2'd1;
    pulse(7);
    expect_rd(0, 32'h0000_0204, 0, 1, 0, "R6 code 1");
    wr(0, 32'hFFFF_FFFF);
    expect_rd(0, 32'h0, 0, 0, 0, "R6 all cleared");

    set_levels(1);
    expect_rd(0, 32'h3F00_40C0, 0, 0, 0, "R5 levels follow inputs");
    wr(0, 32'hFFFF_FFFF);
    expect_rd(0, 32'h3F00_40C0, 0, 0, 0, "R5 levels ignore clear write");
    set_levels(0);
    expect_rd(0, 32'h0, 0, 0, 0, "R5 levels drop");

    wr(1, 32'hFFFF_FFFF);
    expect_rd(1, 32'h0007_F01F, 0, 0, 0, "R8 enable mask");
    wr(1, 32'h4);
    expect_rd(1, 32'h0000_0004, 0, 0, 0, "R8 enable write");
    pulse(2);
    expect_rd(0, 32'h0000_2000, 1, 0, 0, "R9 cmd end enabled");
    expect_rd(1, 32'h0000_0004, 1, 0, 0, "R8 enable holds");
    wr(1, 32'h0);
    expect_rd(0, 32'h0000_2000, 0, 0, 0, "R9 disabled no irq");
    wr(1, 32'h0000_8000);
    pulse(0);
    expect_rd(0, 32'h8000_2000, 1, 0, 0, "R9 card insert enabled");
    wr(0, 32'hFFFF_FFFF);
    expect_rd(0, 32'h0, 0, 0, 0, "R9 irq drops after clear");
    wr(1, 32'h0007_F01F);
    pulse(9);
    expect_rd(0, 32'h0000_0001, 0, 1, 0, "R9 error alone no irq");
    wr(0, 32'h1);
    wr(1, 32'h8);
    @(negedge clk); lv_wr_ready = 1;
    expect_rd(0, 32'h0000_0040, 1, 0, 0, "R9 write ready level irq");
    @(negedge clk); lv_wr_ready = 0;
    expect_rd(0, 32'h0, 0, 0, 0, "R9 level gone");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule